// File: doc/BRIEF.md
# NAND ECC Controller Register Front End

This block is the software-facing side of a BCH error-correction engine used on NAND flash pages. A 32-bit register bus programs a small control word, two byte counts and interrupt enables. It feeds data and parity bytes, one bus write per byte, into the engine. It then reads back parity words, error locations and a status word. The polynomial arithmetic is not part of the block. A result strobe from the engine hands over the parity bytes, the error counts and the error bit indices, and the front end holds them for software.

A typical encode sets the enable, encode and init control bits, writes the page bytes, waits for encode-done and reads the parity words. A typical decode clears the encode bit and writes the page bytes followed by the stored parity. It then waits for decode-done and checks the status. If every byte was 0x00 or every byte was 0xFF, the page is erased or blank and no correction is needed. Otherwise software reads the error count and the bit indices.

Top module: `ecc_regfront`

## Requirements
- R1: The control word reads at offset 0x00 as {mode (bit 3, 1 = encode), strength (bit 2, 1 = 8-bit), init (bit 1), enable (bit 0)}. A write to 0x04 sets the bits given by the mask in wdata[3:0]. A write to 0x08 clears the bits given by that mask. A write to 0x00 changes nothing. Outputs eng_strong_o and eng_encode_o follow bits 2 and 3.
- R2: Setting init makes the bit read 1 for exactly one cycle; it then clears by itself. In that cycle the byte counter restarts at zero, the blank-page trackers are rearmed, and the stored parity and error indices return to zero.
- R3: The count register at 0x0C holds the encode byte count in bits 9:0 and the decode byte count in bits 25:16. All other bits read 0.
- R4: A write to 0x10 is accepted only when the enable bit is 1, init is 0, and the byte counter is below the active count. The active count is the encode count in encode mode and the decode count otherwise. Each accepted byte (wdata[7:0]) appears on eng_byte_o with eng_valid_o high for one cycle, starting in the cycle after the write. Other data writes produce nothing.
- R5: In encode mode, status bit 2 (encode-done) sets on the edge that accepts the byte bringing the counter to the encode count. It stays clear before that byte.
- R6: In decode mode, status bit 3 (decode-done) sets on the edge that accepts the byte bringing the counter to the decode count.
- R7: At decode-done, status bit 4 sets if every byte accepted since init was 0xFF. Status bit 5 sets if every such byte was 0x00. A mixed block sets neither.
- R8: The status word at 0x24 is write-one-to-clear on bits 31:28, 22:16 and 5:0. Writing 0 to a bit leaves it unchanged.
- R9: A result strobe while enabled stores the parity input, which reads back little-endian from 0x14 upward. Word w holds parity bytes 4w to 4w+3, with byte 4w in bits 7:0. In decode mode the strobe also updates the status word. Bits 31:28 take the correctable count and bits 22:16 the total count. Bit 1 sets on uncorrectable. Bit 0 sets when the correctable count is nonzero or the result is uncorrectable. A strobe while disabled changes nothing.
- R10: Error index n reads from the word at 0x28 + 4*(n/2). Even indices sit in bits 12:0, odd indices in bits 28:16, and the other bits read 0.
- R11: The interrupt enables read at 0x38 as a 6-bit mask. Writes to 0x3C set bits of the mask and writes to 0x40 clear them. irq_o is high whenever some status bit among 5:0 and its enable bit are both 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_i | input | 1 | Bus access strobe |
| we_i | input | 1 | Bus write when 1, read when 0 |
| addr_i | input | 7 | Byte address, word aligned |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Read data, combinational from addr_i |
| eng_valid_o | output | 1 | Byte stream valid to the engine |
| eng_byte_o | output | 8 | Byte to the engine |
| eng_strong_o | output | 1 | 8-bit correction strength selected |
| eng_encode_o | output | 1 | Encode mode selected |
| res_valid_i | input | 1 | Engine result strobe |
| res_parity_i | input | PAR_WORDS*32 | Parity bytes, byte k in bits 8k+7:8k |
| res_idx_i | input | 2*ERR_WORDS*IDX_W | Error bit indices, index n in bits IDX_W*n+IDX_W-1:IDX_W*n |
| res_err_cnt_i | input | 4 | Correctable error count |
| res_tot_cnt_i | input | 7 | Total error count |
| res_uncor_i | input | 1 | Block uncorrectable |
| irq_o | output | 1 | Interrupt request |

## Verification
The bound checker watches, on every cycle, the rules that can be stated locally. Control bits change only through the alias writes. Init clears itself and zeroes the byte counter. The counter only steps by one or returns to zero. No byte streams while the block is disabled. Encode-done rises only at the programmed count. The interrupt never fires without a pending flag. The bench scenarios cover what needs whole transactions. These include the exact byte order on the engine port, the blank-page flags for all-0xFF, all-0x00 and mixed blocks, and the status and index word layouts after a result. They also show a counter restart forced by a mid-stream init, and write-one-to-clear against zero writes.

// File: rtl/ecc_fe_pkg.sv
package ecc_fe_pkg;
  // word indices (byte address / 4)
  localparam logic [4:0] W_CTRL = 5'd0;
  localparam logic [4:0] W_SET  = 5'd1;
  localparam logic [4:0] W_CLR  = 5'd2;
  localparam logic [4:0] W_CNT  = 5'd3;
  localparam logic [4:0] W_DATA = 5'd4;
  localparam logic [4:0] W_PAR0 = 5'd5;
  localparam logic [4:0] W_STAT = 5'd9;
  localparam logic [4:0] W_ERR0 = 5'd10;
  localparam logic [4:0] W_INTE = 5'd14;
  localparam logic [4:0] W_ISET = 5'd15;
  localparam logic [4:0] W_ICLR = 5'd16;

  localparam int C_EN   = 0;
  localparam int C_INIT = 1;
  localparam int C_STR  = 2;
  localparam int C_ENC  = 3;

  localparam int S_ERR  = 0;
  localparam int S_UNC  = 1;
  localparam int S_ENCD = 2;
  localparam int S_DECD = 3;
  localparam int S_FF   = 4;
  localparam int S_00   = 5;
  localparam int S_TOT  = 16;
  localparam int S_ERRC = 28;

  localparam int N_FLAGS = 6;
  localparam logic [31:0] STAT_MASK = 32'hF07F_003F;
endpackage

// File: rtl/ecc_fe_setclr.sv
module ecc_fe_setclr #(
  parameter int W = 4
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] set_i,
  input  logic [W-1:0] clr_i,
  output logic [W-1:0] q_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) q_o <= '0;
    else         q_o <= (q_o & ~clr_i) | set_i;
  end
endmodule

// File: rtl/ecc_fe_stream.sv
module ecc_fe_stream #(
  parameter int CNT_W = 10
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             init_i,
  input  logic             en_i,
  input  logic             encode_i,
  input  logic [CNT_W-1:0] enc_cnt_i,
  input  logic [CNT_W-1:0] dec_cnt_i,
  input  logic             wr_i,
  input  logic [7:0]       byte_i,
  output logic             eng_valid_o,
  output logic [7:0]       eng_byte_o,
  output logic             enc_done_o,
  output logic             dec_done_o,
  output logic             all_ff_o,
  output logic             all_00_o,
  output logic [CNT_W-1:0] byte_cnt_o
);
  logic [CNT_W-1:0] cnt_q, target;
  logic ff_q, zz_q, accept, last, is_ff, is_00;

  always_comb begin
    target     = encode_i ? enc_cnt_i : dec_cnt_i;
    accept     = wr_i && en_i && !init_i && (cnt_q < target);
    last       = accept && ((cnt_q + CNT_W'(1)) == target);
    is_ff      = (byte_i == 8'hFF);
    is_00      = (byte_i == 8'h00);
    enc_done_o = last && encode_i;
    dec_done_o = last && !encode_i;
    all_ff_o   = dec_done_o && ff_q && is_ff;
    all_00_o   = dec_done_o && zz_q && is_00;
    byte_cnt_o = cnt_q;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q       <= '0;
      ff_q        <= 1'b1;
      zz_q        <= 1'b1;
      eng_valid_o <= 1'b0;
      eng_byte_o  <= '0;
    end else begin
      eng_valid_o <= accept;
      if (accept) eng_byte_o <= byte_i;
      if (init_i) begin
        cnt_q <= '0;
        ff_q  <= 1'b1;
        zz_q  <= 1'b1;
      end else if (accept) begin
        cnt_q <= cnt_q + CNT_W'(1);
        ff_q  <= ff_q & is_ff;
        zz_q  <= zz_q & is_00;
      end
    end
  end
endmodule

// File: rtl/ecc_fe_results.sv
module ecc_fe_results #(
  parameter int PAR_WORDS = 4,
  parameter int ERR_WORDS = 4,
  parameter int IDX_W     = 13
) (
  input  logic                           clk_i,
  input  logic                           rst_ni,
  input  logic                           clr_i,
  input  logic                           cap_i,
  input  logic [PAR_WORDS*32-1:0]        parity_i,
  input  logic [2*ERR_WORDS*IDX_W-1:0]   idx_i,
  output logic [PAR_WORDS-1:0][31:0]     par_words_o,
  output logic [ERR_WORDS-1:0][31:0]     err_words_o
);
  localparam int N_IDX = 2 * ERR_WORDS;
  localparam int PAD   = 16 - IDX_W;

  logic [PAR_WORDS*32-1:0]    par_q;
  logic [N_IDX*IDX_W-1:0]     idx_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      par_q <= '0;
      idx_q <= '0;
    end else if (clr_i) begin
      par_q <= '0;
      idx_q <= '0;
    end else if (cap_i) begin
      par_q <= parity_i;
      idx_q <= idx_i;
    end
  end

  for (genvar w = 0; w < PAR_WORDS; w++) begin : g_par
    assign par_words_o[w] = par_q[32*w +: 32];
  end

  for (genvar w = 0; w < ERR_WORDS; w++) begin : g_err
    assign err_words_o[w] = {{PAD{1'b0}}, idx_q[IDX_W*(2*w+1) +: IDX_W],
                             {PAD{1'b0}}, idx_q[IDX_W*(2*w) +: IDX_W]};
  end
endmodule

// File: rtl/ecc_regfront.sv
module ecc_regfront
  import ecc_fe_pkg::*;
#(
  parameter int CNT_W     = 10,
  parameter int PAR_WORDS = 4,
  parameter int ERR_WORDS = 4,
  parameter int IDX_W     = 13
) (
  input  logic                         clk_i,
  input  logic                         rst_ni,
  input  logic                         req_i,
  input  logic                         we_i,
  input  logic [6:0]                   addr_i,
  input  logic [31:0]                  wdata_i,
  output logic [31:0]                  rdata_o,
  output logic                         eng_valid_o,
  output logic [7:0]                   eng_byte_o,
  output logic                         eng_strong_o,
  output logic                         eng_encode_o,
  input  logic                         res_valid_i,
  input  logic [PAR_WORDS*32-1:0]      res_parity_i,
  input  logic [2*ERR_WORDS*IDX_W-1:0] res_idx_i,
  input  logic [3:0]                   res_err_cnt_i,
  input  logic [6:0]                   res_tot_cnt_i,
  input  logic                         res_uncor_i,
  output logic                         irq_o
);
  logic [4:0] widx;
  logic       hit, wr;
  logic [3:0] ctrl_q, ctrl_set, ctrl_clr;
  logic [N_FLAGS-1:0] inte_q, inte_set, inte_clr;
  logic [CNT_W-1:0] enc_cnt_q, dec_cnt_q, byte_cnt;
  logic [31:0] stat_q, stat_d;
  logic enc_done, dec_done, all_ff, all_00, cap;
  logic [PAR_WORDS-1:0][31:0] par_words;
  logic [ERR_WORDS-1:0][31:0] err_words;

  assign widx = addr_i[6:2];
  assign hit  = req_i && (addr_i[1:0] == 2'b00);
  assign wr   = hit && we_i;

  // init self-clears one cycle after it was set
  assign ctrl_set = (wr && widx == W_SET) ? wdata_i[3:0] : 4'h0;
  assign ctrl_clr = ((wr && widx == W_CLR) ? wdata_i[3:0] : 4'h0)
                  | {2'b00, ctrl_q[C_INIT], 1'b0};
  assign inte_set = (wr && widx == W_ISET) ? wdata_i[N_FLAGS-1:0] : '0;
  assign inte_clr = (wr && widx == W_ICLR) ? wdata_i[N_FLAGS-1:0] : '0;

  ecc_fe_setclr #(.W(4)) u_ctrl (
    .clk_i, .rst_ni, .set_i(ctrl_set), .clr_i(ctrl_clr), .q_o(ctrl_q)
  );

  ecc_fe_setclr #(.W(N_FLAGS)) u_inte (
    .clk_i, .rst_ni, .set_i(inte_set), .clr_i(inte_clr), .q_o(inte_q)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      enc_cnt_q <= '0;
      dec_cnt_q <= '0;
    end else if (wr && widx == W_CNT) begin
      enc_cnt_q <= wdata_i[CNT_W-1:0];
      dec_cnt_q <= wdata_i[16 +: CNT_W];
    end
  end

  ecc_fe_stream #(.CNT_W(CNT_W)) u_stream (
    .clk_i, .rst_ni,
    .init_i     (ctrl_q[C_INIT]),
    .en_i       (ctrl_q[C_EN]),
    .encode_i   (ctrl_q[C_ENC]),
    .enc_cnt_i  (enc_cnt_q),
    .dec_cnt_i  (dec_cnt_q),
    .wr_i       (wr && widx == W_DATA),
    .byte_i     (wdata_i[7:0]),
    .eng_valid_o,
    .eng_byte_o,
    .enc_done_o (enc_done),
    .dec_done_o (dec_done),
    .all_ff_o   (all_ff),
    .all_00_o   (all_00),
    .byte_cnt_o (byte_cnt)
  );

  assign cap = res_valid_i && ctrl_q[C_EN] && !ctrl_q[C_INIT];

  ecc_fe_results #(.PAR_WORDS(PAR_WORDS), .ERR_WORDS(ERR_WORDS), .IDX_W(IDX_W)) u_res (
    .clk_i, .rst_ni,
    .clr_i      (ctrl_q[C_INIT]),
    .cap_i      (cap),
    .parity_i   (res_parity_i),
    .idx_i      (res_idx_i),
    .par_words_o(par_words),
    .err_words_o(err_words)
  );

  always_comb begin
    stat_d = stat_q;
    if (wr && widx == W_STAT) stat_d = stat_d & ~(wdata_i & STAT_MASK);
    if (enc_done) stat_d[S_ENCD] = 1'b1;
    if (dec_done) stat_d[S_DECD] = 1'b1;
    if (all_ff)   stat_d[S_FF]   = 1'b1;
    if (all_00)   stat_d[S_00]   = 1'b1;
    if (cap && !ctrl_q[C_ENC]) begin
      if (res_uncor_i || res_err_cnt_i != 4'd0) stat_d[S_ERR] = 1'b1;
      if (res_uncor_i) stat_d[S_UNC] = 1'b1;
      stat_d[S_TOT +: 7]  = res_tot_cnt_i;
      stat_d[S_ERRC +: 4] = res_err_cnt_i;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) stat_q <= '0;
    else         stat_q <= stat_d;
  end

  assign irq_o        = |(stat_q[N_FLAGS-1:0] & inte_q);
  assign eng_strong_o = ctrl_q[C_STR];
  assign eng_encode_o = ctrl_q[C_ENC];

  always_comb begin
    rdata_o = '0;
    if (hit && !we_i) begin
      case (widx)
        W_CTRL:  rdata_o = {28'h0, ctrl_q};
        W_CNT:   rdata_o = (32'(dec_cnt_q) << 16) | 32'(enc_cnt_q);
        W_STAT:  rdata_o = stat_q;
        W_INTE:  rdata_o = {{(32-N_FLAGS){1'b0}}, inte_q};
        default: rdata_o = '0;
      endcase
      for (int i = 0; i < PAR_WORDS; i++)
        if (widx == 5'(W_PAR0 + 5'(i))) rdata_o = par_words[i];
      for (int i = 0; i < ERR_WORDS; i++)
        if (widx == 5'(W_ERR0 + 5'(i))) rdata_o = err_words[i];
    end
  end
endmodule

// File: rtl/ecc_regfront_chk.sv
module ecc_regfront_chk
  import ecc_fe_pkg::*;
#(
  parameter int CNT_W = 10
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             req_i,
  input logic             we_i,
  input logic [6:0]       addr_i,
  input logic [31:0]      wdata_i,
  input logic [3:0]       ctrl_i,
  input logic [CNT_W-1:0] byte_cnt_i,
  input logic [CNT_W-1:0] enc_cnt_i,
  input logic [31:0]      stat_i,
  input logic             eng_valid_i,
  input logic             irq_i
);
  logic alias_wr, set_init, data_wr;
  assign alias_wr = req_i && we_i && (addr_i[6:2] == W_SET || addr_i[6:2] == W_CLR);
  assign set_init = req_i && we_i && addr_i[6:2] == W_SET && wdata_i[C_INIT];
  assign data_wr  = req_i && we_i && addr_i[6:2] == W_DATA;

  a_r1_ctrl_only_via_alias: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !alias_wr |=> (ctrl_i[C_EN] == $past(ctrl_i[C_EN]) && ctrl_i[C_STR] == $past(ctrl_i[C_STR])
                   && ctrl_i[C_ENC] == $past(ctrl_i[C_ENC])));

  a_r2_init_one_cycle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ctrl_i[C_INIT] && !set_init) |=> !ctrl_i[C_INIT]);

  a_r2_init_zeroes_count: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ctrl_i[C_INIT] |=> byte_cnt_i == '0);

  a_r4_count_steps: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (byte_cnt_i != $past(byte_cnt_i)) |->
      (byte_cnt_i == $past(byte_cnt_i) + CNT_W'(1) || byte_cnt_i == '0));

  a_r4_quiet_when_off: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (data_wr && !ctrl_i[C_EN]) |=> !eng_valid_i);

  a_r5_enc_done_at_count: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(stat_i[S_ENCD]) |-> byte_cnt_i == enc_cnt_i);

  a_r11_irq_needs_flag: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_i |-> stat_i[N_FLAGS-1:0] != '0);
endmodule

bind ecc_regfront ecc_regfront_chk #(.CNT_W(CNT_W)) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .req_i      (req_i),
  .we_i       (we_i),
  .addr_i     (addr_i),
  .wdata_i    (wdata_i),
  .ctrl_i     (ctrl_q),
  .byte_cnt_i (byte_cnt),
  .enc_cnt_i  (enc_cnt_q),
  .stat_i     (stat_q),
  .eng_valid_i(eng_valid_o),
  .irq_i      (irq_o)
);

// File: tb/ecc_regfront_bench.sv
`timescale 1ns/1ps
module ecc_regfront_bench;
  localparam int PAR_WORDS = 4;
  localparam int ERR_WORDS = 4;
  localparam int IDX_W     = 13;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic req = 1'b0, we = 1'b0;
  logic [6:0] addr = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic eng_valid, eng_strong, eng_encode, irq;
  logic [7:0] eng_byte;
  logic res_valid = 1'b0;
  logic [PAR_WORDS*32-1:0] res_parity = '0;
  logic [2*ERR_WORDS*IDX_W-1:0] res_idx = '0;
  logic [3:0] res_err = '0;
  logic [6:0] res_tot = '0;
  logic res_uncor = 1'b0;

  int n_chk = 0, n_fail = 0;
  logic rd_go = 1'b0;
  logic [31:0] exp_rd_q[$];
  string       exp_tag_q[$];
  logic [7:0]  exp_byte_q[$];
  logic [31:0] par_pat;

  always #2 clk = ~clk;

  ecc_regfront u_ecc_regfront (
    .clk_i(clk), .rst_ni(rst_n), .req_i(req), .we_i(we), .addr_i(addr),
    .wdata_i(wdata), .rdata_o(rdata), .eng_valid_o(eng_valid),
    .eng_byte_o(eng_byte), .eng_strong_o(eng_strong), .eng_encode_o(eng_encode),
    .res_valid_i(res_valid), .res_parity_i(res_parity), .res_idx_i(res_idx),
    .res_err_cnt_i(res_err), .res_tot_cnt_i(res_tot), .res_uncor_i(res_uncor),
    .irq_o(irq)
  );

  task automatic report(string tag, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual 0x%08h expected 0x%08h", tag, act, exp);
    end
  endtask

  // monitor: pops the scoreboard on reads and on engine bytes
  always @(negedge clk) begin
    if (rd_go) begin
      if (exp_rd_q.size() == 0) report("R0 read without expectation", rdata, 32'hx);
      else report(exp_tag_q.pop_front(), rdata, exp_rd_q.pop_front());
    end
    if (eng_valid) begin
      if (exp_byte_q.size() == 0) report("R4 unexpected engine byte", {24'h0, eng_byte}, 32'hFFFF_FFFF);
      else report("R4 engine byte", {24'h0, eng_byte}, {24'h0, exp_byte_q.pop_front()});
    end
  end

  task automatic bus_wr(logic [6:0] a, logic [31:0] d);
    @(posedge clk); #1;
    req = 1'b1; we = 1'b1; addr = a; wdata = d;
    @(posedge clk); #1;
    req = 1'b0; we = 1'b0;
  endtask

  task automatic rd_exp(logic [6:0] a, logic [31:0] exp, string tag);
    exp_rd_q.push_back(exp);
    exp_tag_q.push_back(tag);
    @(posedge clk); #1;
    req = 1'b1; we = 1'b0; addr = a; rd_go = 1'b1;
    @(posedge clk); #1;
    req = 1'b0; rd_go = 1'b0;
  endtask

  task automatic data_wr(logic [7:0] b, bit accepted);
    if (accepted) exp_byte_q.push_back(b);
    bus_wr(7'h10, {24'h0, b});
  endtask

  task automatic port_chk(string tag, logic act, logic exp);
    @(negedge clk);
    report(tag, {31'h0, act}, {31'h0, exp});
  endtask

  task automatic give_result(logic [3:0] e, logic [6:0] t, logic u);
    @(posedge clk); #1;
    res_valid = 1'b1; res_err = e; res_tot = t; res_uncor = u;
    @(posedge clk); #1;
    res_valid = 1'b0;
  endtask

  task automatic set_idx(int n, logic [IDX_W-1:0] v);
    res_idx[IDX_W*n +: IDX_W] = v;
  endtask

  task automatic finish_run();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    for (int k = 0; k < PAR_WORDS * 4; k++) res_parity[8*k +: 8] = 8'(k);
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;

    // reset state
    rd_exp(7'h00, 32'h0, "R1 ctrl after reset");
    rd_exp(7'h24, 32'h0, "R8 status after reset");
    rd_exp(7'h0C, 32'h0, "R3 count after reset");
    port_chk("R11 irq after reset", irq, 1'b0);

    // count register layout
    bus_wr(7'h0C, 32'hFFFF_FFFF);
    rd_exp(7'h0C, 32'h03FF_03FF, "R3 count field mask");
    bus_wr(7'h0C, 32'h0009_0005);
    rd_exp(7'h0C, 32'h0009_0005, "R3 count readback");

    // data while disabled, direct ctrl write
    data_wr(8'hAA, 1'b0);
    bus_wr(7'h00, 32'hF);
    rd_exp(7'h00, 32'h0, "R1 write to ctrl ignored");

    // encode: enable|init|encode
    bus_wr(7'h04, 32'hB);
    rd_exp(7'h00, 32'h9, "R2 init self-cleared");
    port_chk("R1 encode output", eng_encode, 1'b1);
    port_chk("R1 strength output", eng_strong, 1'b0);
    for (int i = 0; i < 4; i++) data_wr(8'(8'h11 + i), 1'b1);
    rd_exp(7'h24, 32'h0, "R5 no encode-done before count");
    data_wr(8'h15, 1'b1);
    rd_exp(7'h24, 32'h4, "R5 encode-done at count");
    data_wr(8'h16, 1'b0);

    give_result(4'd2, 7'd3, 1'b0);
    rd_exp(7'h24, 32'h4, "R9 encode result leaves status");
    rd_exp(7'h14, 32'h0302_0100, "R9 parity word 0");
    rd_exp(7'h20, 32'h0F0E_0D0C, "R9 parity word 3");

    // interrupts
    port_chk("R11 irq masked", irq, 1'b0);
    bus_wr(7'h3C, 32'h4);
    port_chk("R11 irq enabled", irq, 1'b1);
    rd_exp(7'h38, 32'h4, "R11 enable readback");
    bus_wr(7'h40, 32'h4);
    port_chk("R11 irq after enable clear", irq, 1'b0);

    // write-one-to-clear
    bus_wr(7'h24, 32'h0);
    rd_exp(7'h24, 32'h4, "R8 zero write keeps status");
    bus_wr(7'h24, 32'h4);
    rd_exp(7'h24, 32'h0, "R8 one write clears");

    // decode, strength 8, all 0xFF
    bus_wr(7'h08, 32'h8);
    bus_wr(7'h04, 32'h6);
    rd_exp(7'h00, 32'h5, "R1 decode ctrl");
    port_chk("R1 strength set", eng_strong, 1'b1);
    port_chk("R1 decode output", eng_encode, 1'b0);
    rd_exp(7'h14, 32'h0, "R2 parity cleared by init");
    for (int i = 0; i < 8; i++) data_wr(8'hFF, 1'b1);
    rd_exp(7'h24, 32'h0, "R6 no decode-done before count");
    data_wr(8'hFF, 1'b1);
    rd_exp(7'h24, 32'h18, "R6 R7 decode-done with all-FF");

    set_idx(0, 13'h0123); set_idx(1, 13'h1ABC);
    set_idx(2, 13'h0007); set_idx(3, 13'h1FFF);
    give_result(4'd3, 7'd5, 1'b0);
    rd_exp(7'h24, 32'h3005_0019, "R9 decode status fields");
    rd_exp(7'h28, 32'h1ABC_0123, "R10 index word 0");
    rd_exp(7'h2C, 32'h1FFF_0007, "R10 index word 1");
    rd_exp(7'h34, 32'h0, "R10 index word 3 empty");

    bus_wr(7'h3C, 32'h10);
    port_chk("R11 irq on all-FF", irq, 1'b1);
    bus_wr(7'h24, 32'hFFFF_FFFF);
    rd_exp(7'h24, 32'h0, "R8 clear all");
    port_chk("R11 irq drops with flag", irq, 1'b0);

    // all zeros
    bus_wr(7'h04, 32'h2);
    rd_exp(7'h28, 32'h0, "R2 indices cleared by init");
    for (int i = 0; i < 9; i++) data_wr(8'h00, 1'b1);
    rd_exp(7'h24, 32'h28, "R7 all-00 flag");
    bus_wr(7'h24, 32'hFFFF_FFFF);

    // init mid-stream restarts the count, then a mixed block
    bus_wr(7'h04, 32'h2);
    for (int i = 0; i < 3; i++) data_wr(8'h00, 1'b1);
    bus_wr(7'h04, 32'h2);
    for (int i = 0; i < 8; i++) data_wr(8'h00, 1'b1);
    rd_exp(7'h24, 32'h0, "R2 counter restarted by init");
    data_wr(8'h01, 1'b1);
    rd_exp(7'h24, 32'h08, "R7 mixed block sets no flag");
    give_result(4'd0, 7'd0, 1'b1);
    rd_exp(7'h24, 32'h0B, "R9 uncorrectable");

    // disabled
    bus_wr(7'h08, 32'h1);
    bus_wr(7'h24, 32'hFFFF_FFFF);
    bus_wr(7'h04, 32'h2);
    bus_wr(7'h08, 32'h1);
    data_wr(8'h55, 1'b0);
    give_result(4'd1, 7'd1, 1'b0);
    rd_exp(7'h24, 32'h0, "R9 result ignored while disabled");
    rd_exp(7'h28, 32'h0, "R9 indices not captured while disabled");

    repeat (3) @(posedge clk);
    report("R4 all expected bytes streamed", 32'(exp_byte_q.size()), 32'h0);
    finish_run();
  end
endmodule